// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Handshake

This block joins one bus initiator and one responder that sit in unrelated clock domains. The initiator takes a read or write command from its local side. It drives the target address, the direction and any write data onto the shared lines. It holds those lines for a programmable settle interval so the responder's address decode can resolve, and only then raises `req`. The responder samples `req` through a two-stage synchronizer and services the command against a small local register store. It answers with `ack`. Both sides then return to zero: `req` drops once the initiator has seen `ack`, and `ack` drops once the responder has seen `req` fall.

The meaning of `ack` depends on the direction. On a write, a rising `ack` says the responder has stored the data. On a read, a rising `ack` says the read data is on the lines. The initiator latches that data in the same cycle it lets `req` fall. The responder holds its read data unchanged until it sees `req` go low. A new command is taken only after `ack` has returned low.

The initiator has four states. `M_IDLE` takes a command (IDLE→SETTLE on `cmd_valid`). `M_SETTLE` counts the decode interval (SETTLE→REQ when the count ends). `M_REQ` drives `req` high (REQ→RELEASE when the synchronized `ack` is high, which also captures read data). `M_RELEASE` waits (RELEASE→IDLE when the synchronized `ack` is low, which pulses `done`). The responder has two states. `S_IDLE` waits for `req` (IDLE→ACK when the synchronized `req` is high, which performs the store or the fetch). `S_ACK` holds `ack` high (ACK→IDLE when the synchronized `req` is low).

Top module: `hs4_bus_top`

## Requirements
- R1: During and right after reset, `cmd_ready` is 1 and `bus_req`, `bus_ack` and `done` are 0.
- R2: `bus_req` rises exactly DECODE_CYC initiator clock cycles after the rising edge that accepts a command (`cmd_valid` and `cmd_ready` both high), with DECODE_CYC of at least 1.
- R3: The handshake lines move only in the cycle 00→10→11→01→00, written as (req, ack). `req` falls only after the initiator has seen `ack` high, and `ack` rises only while the responder sees `req` high and falls only after it sees `req` low.
- R4: A write stores `cmd_wdata` at `cmd_addr` by the time `ack` rises, so a later read of that address returns it.
- R5: A read returns, on `rd_data`, the value last written to `cmd_addr`. The initiator captures it when it drops `req`, and `rd_data` keeps it until the next read completes.
- R6: `bus_addr`, the direction and the write data stay constant from the cycle after acceptance until the transfer completes.
- R7: `cmd_ready` is 0 from acceptance until the transfer completes. A `cmd_valid` raised in that time starts no transfer.
- R8: While `bus_ack` is high on a read, `bus_rdata` does not change.
- R9: After reset, every location of the responder store reads as 0 until it is written.
- R10: `done` is high for exactly one initiator cycle per transfer. That cycle follows the initiator seeing `ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Initiator clock |
| rst_m_n | input | 1 | Initiator reset, active low |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Initiator idle and able to accept |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target location |
| cmd_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last read result |
| bus_req | output | 1 | Request line (observation) |
| bus_ack | output | 1 | Acknowledge line (observation) |
| bus_addr | output | ADDR_W | Address lines (observation) |
| bus_rdata | output | DATA_W | Read data lines (observation) |

## Verification
The initiator and responder clocks are at a 10:17 ratio, so the synchronizer delays shift from one transfer to the next. Single writes followed by reads of the same addresses tell a correct store apart from a dropped or misplaced one. A read of a never-written address separates reset-cleared storage from stale values. An overwrite of an address that was already written catches a responder that keeps only the first write. A sweep over every address with distinct patterns catches address aliasing. A command held valid during a busy transfer shows whether the initiator wrongly starts a second transfer or disturbs the held address lines.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_SETTLE  = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } mst_state_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_e;

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= {ff_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/hs4_master.sv
module hs4_master
    import hs4_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int DECODE_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    localparam int D_EFF = (DECODE_CYC < 1) ? 1 : DECODE_CYC;
    localparam int CNT_W = (D_EFF > 1) ? $clog2(D_EFF) : 1;
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(D_EFF - 1);

    mst_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_s;
    logic              req_q, ready_q, done_q, wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (bus_ack),
        .q    (ack_s)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:    if (cmd_valid)          state_d = M_SETTLE;
            M_SETTLE:  if (cnt_q == SETTLE_LAST) state_d = M_REQ;
            M_REQ:     if (ack_s)              state_d = M_RELEASE;
            M_RELEASE: if (!ack_s)             state_d = M_IDLE;
            default:                           state_d = M_IDLE;
        endcase
    end

    // decode settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (state_q != M_SETTLE) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            ready_q <= 1'b1;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            req_q   <= (state_d == M_REQ);
            ready_q <= (state_d == M_IDLE);
            done_q  <= (state_q == M_RELEASE) && (state_d == M_IDLE);
            if (state_q == M_IDLE && cmd_valid) begin
                wr_q    <= cmd_write;
                addr_q  <= cmd_addr;
                wdata_q <= cmd_wdata;
            end
            if (state_q == M_REQ && ack_s && !wr_q)
                rdata_q <= bus_rdata;
        end
    end

    assign cmd_ready = ready_q;
    assign done      = done_q;
    assign rd_data   = rdata_q;
    assign bus_req   = req_q;
    assign bus_write = wr_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

    AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(ack_s)); // R3

    AST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_q && $past(!ready_q)) |-> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q))); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10

    AST_DONE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !ack_s && !req_q); // R10
endmodule

// File: rtl/hs4_slave.sv
module hs4_slave
    import hs4_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack
);
    localparam int DEPTH = 1 << ADDR_W;

    slv_state_e        state_q, state_d;
    logic              req_s;
    logic              ack_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (bus_req),
        .q    (req_s)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_s)  state_d = S_ACK;
            S_ACK:   if (!req_s) state_d = S_IDLE;
            default:             state_d = S_IDLE;
        endcase
    end

    // registered outputs and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ack_q <= (state_d == S_ACK);
            if (state_q == S_IDLE && req_s) begin
                if (bus_write) mem_q[bus_addr] <= bus_wdata;
                else           rdata_q         <= mem_q[bus_addr];
            end
        end
    end

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;

    AST_ACK_RISE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(req_s)); // R3

    AST_ACK_FALL_ON_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(req_s)); // R3

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && $past(ack_q)) |-> $stable(rdata_q)); // R8
endmodule

// File: rtl/hs4_bus_top.sv
module hs4_bus_top #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int DECODE_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              clk_s,
    input  logic              rst_s_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_req,
    output logic              bus_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              bus_write;
    logic [DATA_W-1:0] bus_wdata;

    hs4_master #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .DECODE_CYC (DECODE_CYC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_master (
        .clk      (clk_m),
        .rst_n    (rst_m_n),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_write(cmd_write),
        .cmd_addr (cmd_addr),
        .cmd_wdata(cmd_wdata),
        .done     (done),
        .rd_data  (rd_data),
        .bus_req  (bus_req),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ack  (bus_ack)
    );

    hs4_slave #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_slave (
        .clk      (clk_s),
        .rst_n    (rst_s_n),
        .bus_req  (bus_req),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ack  (bus_ack)
    );
endmodule

// File: tb/hs4_bus_top_tb_top.sv
`timescale 1ns/1ps
module hs4_bus_top_tb_top;
    localparam int CLK_M_PERIOD = 10;
    localparam int CLK_S_PERIOD = 17;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int DECODE = 3;

    logic clk_m = 0, clk_s = 0, rst_m_n = 0, rst_s_n = 0;
    logic cmd_valid = 0, cmd_write = 0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic cmd_ready, done, bus_req, bus_ack;
    logic [DATA_W-1:0] rd_data, bus_rdata;
    logic [ADDR_W-1:0] bus_addr;

    int checks = 0, errors = 0;
    int model_mem [16];
    logic prev_req = 0, prev_ack = 0;
    bit finished = 0;

    always #(CLK_M_PERIOD/2.0) clk_m = ~clk_m;
    always #(CLK_S_PERIOD/2.0) clk_s = ~clk_s;

    hs4_bus_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE), .SYNC_STAGES(2)) dut_i (
        .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .done(done), .rd_data(rd_data),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference phase model of (req, ack), stepped on every initiator clock
    always @(negedge clk_m) begin
        if (rst_m_n && rst_s_n) begin
            if ({prev_req, prev_ack} != {bus_req, bus_ack}) begin
                int nxt;
                unique case ({prev_req, prev_ack})
                    2'b00: nxt = 2'b10;
                    2'b10: nxt = 2'b11;
                    2'b11: nxt = 2'b01;
                    default: nxt = 2'b00;
                endcase
                check("R3", "handshake phase step", int'({bus_req, bus_ack}), nxt);
            end
        end
        prev_req = bus_req;
        prev_ack = bus_ack;
    end

    task automatic do_op(bit wr, int addr, int data, bit poke);
        int  cnt = 0;
        bit  seen_req = 0, addr_bad = 0, held_seen = 0, held_bad = 0;
        int  held_val = 0, req_cnt = -1;
        bit  got_done = 0;
        @(negedge clk_m);
        #2;
        cmd_valid = 1; cmd_write = wr;
        cmd_addr = ADDR_W'(addr); cmd_wdata = DATA_W'(data);
        @(negedge clk_m);
        check("R7", "cmd_ready after accept", int'(cmd_ready), 0);
        if (bus_addr != ADDR_W'(addr)) addr_bad = 1;
        #2;
        if (poke) begin
            cmd_addr = ADDR_W'(addr ^ 5); cmd_write = ~wr; cmd_wdata = DATA_W'(16'h7777);
        end else cmd_valid = 0;
        while (!got_done && cnt < 2000) begin
            @(negedge clk_m);
            cnt++;
            if (bus_addr != ADDR_W'(addr)) addr_bad = 1;
            if (!seen_req && bus_req) begin seen_req = 1; req_cnt = cnt; end
            if (seen_req && poke) begin #1; cmd_valid = 0; poke = 0; end
            if (bus_ack && !wr) begin
                if (!held_seen) begin held_seen = 1; held_val = int'(bus_rdata); end
                else if (int'(bus_rdata) != held_val) held_bad = 1;
            end
            if (done) got_done = 1;
            else if (cmd_ready) begin end
        end
        cmd_valid = 0;
        check("R10", "transfer completed with done", int'(got_done), 1);
        check("R2", "cycles from accept to req rise", req_cnt, DECODE);
        check("R6", "address lines held", int'(addr_bad), 0);
        if (wr) model_mem[addr] = data & 16'hFFFF;
        else begin
            check("R8", "read data held while ack high", int'(held_bad), 0);
            check("R5", "read data returned", int'(rd_data), model_mem[addr]);
        end
        @(negedge clk_m);
        check("R10", "done lasts one cycle", int'(done), 0);
        if (!wr) check("R5", "rd_data kept after read", int'(rd_data), model_mem[addr]);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model_mem[i] = 0;
        repeat (3) @(negedge clk_m);
        check("R1", "cmd_ready in reset", int'(cmd_ready), 1);
        check("R1", "req in reset", int'(bus_req), 0);
        check("R1", "ack in reset", int'(bus_ack), 0);
        check("R1", "done in reset", int'(done), 0);
        rst_m_n = 1; rst_s_n = 1;
        repeat (2) @(negedge clk_m);
        check("R1", "cmd_ready after reset", int'(cmd_ready), 1);
        check("R1", "req after reset", int'(bus_req), 0);

        // R4: single writes, then read back
        do_op(1, 3, 16'h1234, 0);
        do_op(1, 7, 16'hBEEF, 0);
        do_op(1, 0, 16'h0001, 0);
        do_op(1, 15, 16'hFFFF, 0);
        do_op(0, 3, 0, 0);
        do_op(0, 7, 0, 0);
        // R9: never-written location
        do_op(0, 5, 0, 0);
        check("R9", "unwritten location", int'(rd_data), 0);
        // R7: overwrite while poking cmd_valid during the transfer
        do_op(1, 3, 16'h5A5A, 1);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk_m);
            if (bus_req || !cmd_ready) begin
                check("R7", "no transfer from busy-time command", 1, 0);
                break;
            end
        end
        check("R7", "idle after busy-time command", int'(cmd_ready), 1);
        do_op(0, 3, 0, 0);
        check("R4", "overwrite stored", int'(rd_data), 16'h5A5A);
        do_op(0, 10, 0, 0);
        check("R9", "location 10 still zero", int'(rd_data), 0);
        do_op(0, 15, 0, 0);
        do_op(0, 0, 0, 0);
        // R4: sweep all addresses
        for (int a = 0; a < 16; a++) do_op(1, a, ((a * 16'h1111) ^ 16'h0F0F) & 16'hFFFF, 0);
        for (int a = 15; a >= 0; a--) begin
            do_op(0, a, 0, 0);
            check("R4", "sweep readback", int'(rd_data), ((a * 16'h1111) ^ 16'h0F0F) & 16'hFFFF);
        end
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_M_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule